// File: doc/BRIEF.md
# I2C Register Target with Two-Byte Addressing

This block is a target on a two-wire serial bus. It gives an external bus controller byte-wide read and write access to a register space of 65,536 locations. The register address is 16 bits wide and arrives as two bytes. The block oversamples the bus clock and data lines with a fast system clock, so it needs no clock from the bus. Each line passes through a spike filter that rejects pulses shorter than 50 ns. After filtering, the block finds START, repeated START and STOP conditions and compares the incoming device address with its own.

The device address is seven bits. The upper four bits are fixed at `1001`. The lower three come from strap pins, which are captured once when reset is released. A write carries the register address high byte first, then the low byte, and then any number of data bytes. A read sets the address with a short write, then sends a repeated START with the read bit set, and data is returned from that address. The address counts up after every byte in both directions and wraps from 0xFFFF to 0x0000.

The register-file side is a plain synchronous port. It carries no valid/ready handshake and offers no back-pressure, because the bus cannot be held off: the block never drives the clock line. A write strobe lasts one cycle. A read is combinational: `reg_rdata` must reflect `reg_addr` in the same cycle that `reg_re` is high. The data line is open-drain. `sda_oe` high means "pull low".

Top module: `i2c_reg_target`

## Requirements
- R1: A pulse on either bus line is ignored if it is shorter than the filter length. The filter length is ceil(SYS_CLK_MHZ*SPIKE_NS/1000) system cycles, which is 13 cycles (52 ns) by default. A spike of 8 cycles must corrupt no transfer and must not create a START or STOP.
- R2: The device address is {1001, strap[2:0]}, with the strap value captured when reset is released. If the address byte does not match, the block leaves SDA released in the ninth clock and ignores every later byte until the next START.
- R3: A START or STOP is an SDA fall or rise while SCL is high. Either one resets the byte framing. A repeated START, with no STOP before it, begins a new address phase.
- R4: The block acknowledges by pulling SDA low in the ninth clock. It does so after a matching address byte, after each register-address byte and after each written data byte, at both 100 kHz and 400 kHz bus rates.
- R5: In a write, the first two bytes after the address byte load the register address, high byte first. Each later byte produces a one-cycle `reg_we` with the byte on `reg_wdata` and the current address on `reg_addr`. Bytes are received MSB first.
- R6: The register address increments by one after each written or acknowledged read byte, and wraps from 0xFFFF to 0x0000.
- R7: In a read, a byte is fetched with one `reg_re` pulse at the current address and is shifted out MSB first. The first byte comes from the address left by the preceding write.
- R8: When the controller does not acknowledge a read byte, the block releases SDA, issues no further `reg_re`, and stays idle until a START.
- R9: `sda_oe` changes only while SCL is low, after a falling edge. No SCL output exists.
- R10: After reset, `sda_oe` is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset; strap pins are captured on release |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls the data line low (open-drain) |
| strap | input | 3 | Low three bits of the device address |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle reg_re is high |
| reg_re | output | 1 | One-cycle read strobe |

## Verification
Burst writes followed by burst reads through a repeated START show whether the byte order, the MSB-first shifting and the address counter agree. Starting a burst at 0xFFFF separates correct wrap-around from an address that saturates or carries into nothing. A mismatched address followed by a matched repeated START separates "ignore until START" from "ignore until STOP". Spikes injected while the bus is idle, on SDA during SCL high and on SCL during SCL low, show whether the filter stops false START/STOP conditions and extra clock edges. Transfers at the 100 kHz and 400 kHz bus rates show that the acknowledge timing does not depend on the bit period.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  // Byte-framing phase of the target.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,   // receiving device address byte
    PH_AHI,   // receiving register address high byte
    PH_ALO,   // receiving register address low byte
    PH_WR,    // receiving data bytes
    PH_RD,    // transmitting data bytes
    PH_SKIP   // not addressed, wait for START
  } phase_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1001;
endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int FILT_LEN = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  // Output follows the input only after it has differed for FILT_LEN cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        dout <= sync[1];
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_tgt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic        sda_f,
  input  logic [6:0]  dev_addr,
  input  logic [7:0]  reg_rdata,
  output logic        sda_oe,
  output logic [15:0] reg_addr,
  output logic [7:0]  reg_wdata,
  output logic        reg_we,
  output logic        reg_re
);
  phase_t      phase;
  logic [3:0]  bitcnt;   // 0..7 data bits, 8 = ack clock pending, 9 = in ack clock
  logic [7:0]  shreg;
  logic [7:0]  txbuf;
  logic [15:0] addr;
  logic        rnw;
  logic        mnack;
  logic        active;
  logic [2:0]  bidx;

  assign active    = (phase != PH_IDLE) && (phase != PH_SKIP);
  assign bidx      = 3'(4'd7 - bitcnt);
  assign reg_addr  = addr;
  assign reg_wdata = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txbuf  <= '0;
      addr   <= '0;
      rnw    <= 1'b0;
      mnack  <= 1'b0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
      reg_re <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (reg_re) txbuf <= reg_rdata;

      if (start_det) begin
        phase  <= PH_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (phase == PH_RD) begin
              mnack <= sda_f;
              if (!sda_f) begin
                addr   <= addr + 16'd1;
                reg_re <= 1'b1;
              end
            end
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            // Entering the acknowledge clock.
            case (phase)
              PH_DEV: begin
                if (shreg[7:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  rnw    <= shreg[0];
                  reg_re <= shreg[0];
                end else begin
                  phase <= PH_SKIP;
                end
              end
              PH_AHI: begin
                addr[15:8] <= shreg;
                sda_oe     <= 1'b1;
              end
              PH_ALO: begin
                addr[7:0] <= shreg;
                sda_oe    <= 1'b1;
              end
              PH_WR: begin
                reg_we <= 1'b1;
                sda_oe <= 1'b1;
              end
              PH_RD:   sda_oe <= 1'b0;
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            // Leaving the acknowledge clock.
            bitcnt <= '0;
            case (phase)
              PH_DEV: begin
                if (rnw) begin
                  phase  <= PH_RD;
                  sda_oe <= ~txbuf[7];
                end else begin
                  phase  <= PH_AHI;
                  sda_oe <= 1'b0;
                end
              end
              PH_AHI: begin
                phase  <= PH_ALO;
                sda_oe <= 1'b0;
              end
              PH_ALO: begin
                phase  <= PH_WR;
                sda_oe <= 1'b0;
              end
              PH_WR: begin
                addr   <= addr + 16'd1;
                sda_oe <= 1'b0;
              end
              PH_RD: begin
                if (mnack) begin
                  phase  <= PH_SKIP;
                  sda_oe <= 1'b0;
                end else begin
                  sda_oe <= ~txbuf[7];
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (phase == PH_RD) begin
            sda_oe <= ~txbuf[bidx];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int SYS_CLK_MHZ = 250,
  parameter int SPIKE_NS    = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  strap,
  output logic [15:0] reg_addr,
  output logic [7:0]  reg_wdata,
  output logic        reg_we,
  input  logic [7:0]  reg_rdata,
  output logic        reg_re
);
  localparam int FILT_RAW = (SYS_CLK_MHZ * SPIKE_NS + 999) / 1000;
  localparam int FILT_LEN = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam int NLINES   = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_f;
  logic              scl_f, sda_f;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [2:0]        strap_q;
  logic              strap_done;
  logic [6:0]        dev_addr;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_raw[g]),
      .dout (line_f[g])
    );
  end

  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  // Strap pins are captured in the first cycle after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= strap;
      strap_done <= 1'b1;
    end
  end

  assign dev_addr = {DEV_PREFIX, strap_q};

  i2c_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_target_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_f    (sda_f),
    .dev_addr (dev_addr),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we),
    .reg_re   (reg_re)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_oe,
  input logic reg_we,
  input logic reg_re
);
  // R9: data line drive moves only while the filtered clock is low
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);

  // R5: write strobe is a single cycle
  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5: write strobe falls in the low phase of the clock
  assert_we_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_f);

  // R7: read and write strobes never coincide
  assert_we_re_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  // R7: read strobe is a single cycle
  assert_re_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .scl_f (scl_f),
  .sda_oe(sda_oe),
  .reg_we(reg_we),
  .reg_re(reg_re)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic        sda_oe;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_we;
  logic [7:0]  reg_rdata;
  logic        reg_re;
  wire         sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;   // 250 MHz

  i2c_reg_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_re(reg_re)
  );

  localparam logic [7:0] DEVW = 8'h9A;   // 1001_101, write
  localparam logic [7:0] DEVR = 8'h9B;   // 1001_101, read
  localparam logic [7:0] BADW = 8'h90;   // 1001_000, write

  logic [7:0]  mem [256];
  logic [15:0] wlog_a [32];
  logic [7:0]  wlog_d [32];
  int          wcnt = 0;
  int          recnt = 0;
  int          oe_bad = 0;
  logic        oe_prev = 1'b0;
  int          nchk = 0;
  int          nfail = 0;
  int          q = 63;
  bit          done = 0;

  assign reg_rdata = mem[reg_addr[7:0]];

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h3C);

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr[7:0]] <= reg_wdata;
      if (wcnt < 32) begin
        wlog_a[wcnt] <= reg_addr;
        wlog_d[wcnt] <= reg_wdata;
      end
      wcnt <= wcnt + 1;
    end
    if (reg_re) recnt <= recnt + 1;
  end

  always @(negedge clk) begin
    if (rst_n && (sda_oe != oe_prev) && scl_m) oe_bad <= oe_bad + 1;
    oe_prev <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(q);
    sda_m = 1'b0; tick(q);
    scl_m = 1'b0; tick(q);
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; tick(q);
    scl_m = 1'b1; tick(q);
    sda_m = 1'b0; tick(q);
    scl_m = 1'b0; tick(q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(q);
    scl_m = 1'b1; tick(q);
    sda_m = 1'b1; tick(2 * q);
  endtask

  // kind: 0 clean, 1 SDA spike in high phase, 2 SCL spike in low phase
  task automatic bit_out(input bit b, input int kind);
    sda_m = b; tick(q);
    if (kind == 2) begin
      scl_m = 1'b1; tick(8); scl_m = 1'b0; tick(q);
    end
    scl_m = 1'b1; tick(q);
    if (kind == 1) begin
      sda_m = ~b; tick(8); sda_m = b;
    end
    tick(q);
    scl_m = 1'b0; tick(q);
  endtask

  task automatic bit_in(output bit b);
    sda_m = 1'b1; tick(q);
    scl_m = 1'b1; tick(q);
    b = sda_line;
    tick(q);
    scl_m = 1'b0; tick(q);
  endtask

  task automatic byte_out(input logic [7:0] v, input int gpos, input int gkind,
                          output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) bit_out(v[i], (i == gpos) ? gkind : 0);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic byte_in(output logic [7:0] v, input bit nack);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      v[i] = x;
    end
    bit_out(nack, 0);
  endtask

  // Sets the register address with a write header; leaves SCL low.
  task automatic set_addr(input logic [15:0] a, input string req);
    bit ack;
    i2c_start();
    byte_out(DEVW, -1, 0, ack);
    check(ack, req, "device write ack", ack, 1);
    byte_out(a[15:8], -1, 0, ack);
    check(ack, "R4", "addr high ack", ack, 1);
    byte_out(a[7:0], -1, 0, ack);
    check(ack, "R4", "addr low ack", ack, 1);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);
    check(wcnt == 0 && recnt == 0, "R10", "strobes after reset", wcnt + recnt, 0);
  endtask

  task automatic t_write_burst();
    bit ack;
    int w0 = wcnt;
    logic [7:0] d [3] = '{8'h11, 8'h22, 8'h33};
    set_addr(16'h0010, "R4");
    for (int i = 0; i < 3; i++) begin
      byte_out(d[i], -1, 0, ack);
      check(ack, "R4", "data byte ack", ack, 1);
    end
    i2c_stop();
    check(wcnt - w0 == 3, "R5", "write count", wcnt - w0, 3);
    for (int i = 0; i < 3; i++) begin
      check(wlog_a[w0 + i] == 16'h0010 + 16'(i), "R6", "write address",
            wlog_a[w0 + i], 16'h0010 + i);
      check(wlog_d[w0 + i] == d[i], "R5", "write data", wlog_d[w0 + i], d[i]);
    end
  endtask

  task automatic t_read_burst(input logic [15:0] a, input int n, input logic [7:0] exp0,
                              input logic [7:0] exp1, input logic [7:0] exp2);
    bit ack;
    logic [7:0] v;
    logic [7:0] e [3];
    int r0;
    e[0] = exp0; e[1] = exp1; e[2] = exp2;
    set_addr(a, "R4");
    r0 = recnt;
    i2c_rstart();
    byte_out(DEVR, -1, 0, ack);
    check(ack, "R3", "repeated START read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      byte_in(v, i == n - 1);
      check(v == e[i], "R7", "read data", v, e[i]);
    end
    tick(q);
    check(sda_oe == 1'b0, "R8", "SDA released after NACK", sda_oe, 0);
    check(recnt - r0 == n, "R8", "read strobes", recnt - r0, n);
    i2c_stop();
    check(recnt - r0 == n, "R8", "no strobe after NACK", recnt - r0, n);
  endtask

  task automatic t_wrap();
    bit ack;
    int w0 = wcnt;
    set_addr(16'hFFFF, "R4");
    byte_out(8'hC1, -1, 0, ack);
    byte_out(8'hC2, -1, 0, ack);
    i2c_stop();
    check(wlog_a[w0] == 16'hFFFF, "R6", "first wrap address", wlog_a[w0], 16'hFFFF);
    check(wlog_a[w0 + 1] == 16'h0000, "R6", "address after wrap", wlog_a[w0 + 1], 0);
    t_read_burst(16'hFFFF, 2, 8'hC1, 8'hC2, 8'h00);
  endtask

  task automatic t_wrong_addr();
    bit ack;
    int w0 = wcnt;
    i2c_start();
    byte_out(BADW, -1, 0, ack);
    check(!ack, "R2", "mismatched address NACK", ack, 0);
    byte_out(8'h55, -1, 0, ack);
    check(!ack, "R2", "byte ignored after mismatch", ack, 0);
    byte_out(8'h00, -1, 0, ack);
    check(wcnt == w0, "R2", "no write after mismatch", wcnt - w0, 0);
    i2c_rstart();
    byte_out(DEVW, -1, 0, ack);
    check(ack, "R3", "repeated START after mismatch", ack, 1);
    i2c_stop();
  endtask

  task automatic t_glitch();
    bit ack;
    int w0 = wcnt;
    scl_m = 1'b0; tick(8); scl_m = 1'b1; tick(q);
    sda_m = 1'b0; tick(8); sda_m = 1'b1; tick(q);
    check(sda_oe == 1'b0 && wcnt == w0, "R1", "idle spikes ignored", wcnt - w0, 0);
    set_addr(16'h0040, "R1");
    byte_out(8'hA5, 7, 1, ack);
    check(ack, "R1", "ack with SDA spike", ack, 1);
    byte_out(8'h3C, 4, 2, ack);
    check(ack, "R1", "ack with SCL spike", ack, 1);
    i2c_stop();
    check(wcnt - w0 == 2, "R1", "writes with spikes", wcnt - w0, 2);
    check(wlog_d[w0] == 8'hA5, "R1", "data under SDA spike", wlog_d[w0], 8'hA5);
    check(wlog_d[w0 + 1] == 8'h3C, "R1", "data under SCL spike", wlog_d[w0 + 1], 8'h3C);
  endtask

  task automatic t_rates();
    bit ack;
    int w0 = wcnt;
    q = 156;   // 400 kHz
    set_addr(16'h0123, "R4");
    byte_out(8'h5A, -1, 0, ack);
    check(ack, "R4", "400 kHz data ack", ack, 1);
    i2c_stop();
    check(wlog_a[w0] == 16'h0123 && wlog_d[w0] == 8'h5A, "R5", "400 kHz write",
          wlog_d[w0], 8'h5A);
    q = 625;   // 100 kHz
    i2c_start();
    byte_out(DEVW, -1, 0, ack);
    check(ack, "R4", "100 kHz address ack", ack, 1);
    i2c_stop();
    q = 63;
    t_read_burst(16'h0123, 1, 8'h5A, 8'h00, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      check(oe_bad == 0, "R9", "sda_oe moved while SCL high", oe_bad, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(40);
    t_reset();
    t_write_burst();
    t_read_burst(16'h0010, 3, 8'h11, 8'h22, 8'h33);
    t_wrap();
    t_wrong_addr();
    t_glitch();
    t_rates();
    finish_run();
  end
endmodule